// File: doc/BRIEF.md
# Register Configuration Table Engine

This block applies a list of register edits stored in memory. Software or a boot sequencer leaves a table of entries in memory, and each entry names one register together with two masks. A single start pulse carries the table's base address. The engine then fetches each entry, reads the named register over the register bus, forces some bits high and some bits low, and writes the merged value back. It keeps going until it meets an entry whose three words are all zero.

Each entry is three 32-bit words at consecutive word addresses: the target register address at offset 0, the mask of bits to force high at offset 4, and the mask of bits to force low at offset 8. The merged value is `(old & ~lo_mask) | hi_mask`, so the high mask takes priority where the two masks overlap. Both bus ports use a request/acknowledge handshake. A bounded wait turns a handshake that never completes into an error stop instead of a hang.

Top module: `cfg_table_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `mem_req_o` and `reg_req_o` are all low.
- R2: A `start_i` pulse while idle raises `busy_o`. The first entry's words are then read, in order, from `base_i`, `base_i+4` and `base_i+8` (register address, force-high mask, force-low mask).
- R3: For each non-terminating entry, the engine reads the named register and then writes `(old & ~lo_mask) | hi_mask` to the same address. Bits set in both masks end up high.
- R4: Entries are processed in table order, and the pointer advances by 12 bytes per entry. No memory read of the next entry is issued until the previous register write has been acknowledged, and the two ports never request at the same time.
- R5: An entry whose address word, force-high word and force-low word are all zero ends the walk. No register access follows, `busy_o` drops, and `done_o` rises. An entry with address zero but a nonzero mask is applied like any other entry.
- R6: With `TMO_CYCLES`=T, a request left unacknowledged for T consecutive cycles ends the walk with `err_o` and `done_o` high and no further bus access. An acknowledge in the T-th cycle of a request is accepted normally.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The walk in progress continues unchanged.
- R8: `done_o` and `err_o` hold their values until the next accepted start, which clears both in the cycle after the start.
- R9: While a request is waiting for its acknowledge, its address, write-enable and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_i | input | AW | Byte address of the first table entry |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Last walk finished (sticky until next start) |
| err_o | output | 1 | Last walk ended on a handshake timeout |
| mem_req_o | output | 1 | Table memory read request |
| mem_addr_o | output | AW | Table memory byte address |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid this cycle |
| mem_rdata_i | input | DW | Memory read data |
| reg_req_o | output | 1 | Register bus request |
| reg_we_o | output | 1 | Register bus write enable (0 = read) |
| reg_addr_o | output | AW | Register address |
| reg_wdata_o | output | DW | Register write data |
| reg_ack_i | input | 1 | Register acknowledge; read data valid this cycle |
| reg_rdata_i | input | DW | Register read data |

## Verification
The acknowledge of a request and the expiry of the wait limit can land in the same cycle, when a responder answers in the T-th cycle of a request. The bench sweeps the responder latency of both ports from zero up to T-1 and expects every walk to complete with correct register values. It then uses a latency of exactly T, once on each port, and expects an error stop that leaves the untouched registers unchanged.

// File: rtl/cfgw_pkg.sv
// Shared definitions for the configuration table walker.
// Assumes byte addressing and 32-bit table words.
package cfgw_pkg;
    localparam int WORD_BYTES  = 4;
    localparam int ENTRY_WORDS = 3;
    localparam int ENTRY_BYTES = WORD_BYTES * ENTRY_WORDS;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_F_ADR = 3'd1,
        ST_F_HI  = 3'd2,
        ST_F_LO  = 3'd3,
        ST_R_RD  = 3'd4,
        ST_R_WR  = 3'd5
    } walk_state_e;
endpackage

// File: rtl/cfgw_merge.sv
// Bitwise merge of an old register value with force-high and force-low masks.
// Force-high wins on overlap. Purely combinational.
module cfgw_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] old_i,
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    output logic [DW-1:0] new_o
);
    // one mux per bit: forced-high, else forced-low, else keep
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign new_o[b] = hi_i[b] ? 1'b1 : (lo_i[b] ? 1'b0 : old_i[b]);
    end
endmodule

// File: rtl/cfgw_wait_timer.sv
// Counts consecutive cycles in which a request waits for its acknowledge.
// Assumes the wait input drops for at least one cycle between requests
// (the acknowledge cycle). Expires in the LIMIT-th waiting cycle.
module cfgw_wait_timer #(
    parameter int LIMIT = 64,
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_i,
    output logic expire_o
);
    logic [CW-1:0] cnt_q;

    assign expire_o = wait_i && (cnt_q == CW'(LIMIT - 1));

    // count waiting cycles, restart whenever the wait ends
    always_ff @(posedge clk) begin
        if (!rst_n || !wait_i || expire_o) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/cfg_table_walker.sv
// Walks a memory table of {address, force-high, force-low} entries and
// applies a read-modify-write per entry over the register bus. Stops on an
// all-zero entry or on a handshake that exceeds TMO_CYCLES. Assumes
// read data is valid in the acknowledge cycle on both ports.
module cfg_table_walker
    import cfgw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int TMO_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          reg_req_o,
    output logic          reg_we_o,
    output logic [AW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    input  logic          reg_ack_i,
    input  logic [DW-1:0] reg_rdata_i
);
    walk_state_e   state_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] adr_q;
    logic [DW-1:0] hi_q, lo_q, old_q;
    logic [DW-1:0] merged;
    logic          waiting, expire;

    // request and address outputs decoded from the walk state
    always_comb begin
        mem_req_o  = (state_q == ST_F_ADR) || (state_q == ST_F_HI) || (state_q == ST_F_LO);
        reg_req_o  = (state_q == ST_R_RD) || (state_q == ST_R_WR);
        reg_we_o   = (state_q == ST_R_WR);
        busy_o     = (state_q != ST_IDLE);
        unique case (state_q)
            ST_F_HI: mem_addr_o = ptr_q + AW'(WORD_BYTES);
            ST_F_LO: mem_addr_o = ptr_q + AW'(2 * WORD_BYTES);
            default: mem_addr_o = ptr_q;
        endcase
    end

    assign reg_addr_o  = adr_q;
    assign reg_wdata_o = merged;
    assign waiting     = (mem_req_o && !mem_ack_i) || (reg_req_o && !reg_ack_i);

    cfgw_merge #(.DW(DW)) u_merge (
        .old_i (old_q),
        .hi_i  (hi_q),
        .lo_i  (lo_q),
        .new_o (merged)
    );

    cfgw_wait_timer #(.LIMIT(TMO_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_i   (waiting),
        .expire_o (expire)
    );

    // walk sequencer: fetch entry, read target, write merged value, advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            adr_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            old_q   <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else if (expire) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            err_o   <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    ptr_q   <= base_i;
                    done_o  <= 1'b0;
                    err_o   <= 1'b0;
                    state_q <= ST_F_ADR;
                end
                ST_F_ADR: if (mem_ack_i) begin
                    adr_q   <= AW'(mem_rdata_i);
                    state_q <= ST_F_HI;
                end
                ST_F_HI: if (mem_ack_i) begin
                    hi_q    <= mem_rdata_i;
                    state_q <= ST_F_LO;
                end
                ST_F_LO: if (mem_ack_i) begin
                    lo_q <= mem_rdata_i;
                    if (adr_q == '0 && hi_q == '0 && mem_rdata_i == '0) begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                    end else begin
                        state_q <= ST_R_RD;
                    end
                end
                ST_R_RD: if (reg_ack_i) begin
                    old_q   <= reg_rdata_i;
                    state_q <= ST_R_WR;
                end
                ST_R_WR: if (reg_ack_i) begin
                    ptr_q   <= ptr_q + AW'(ENTRY_BYTES);
                    state_q <= ST_F_ADR;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && reg_req_o));
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !expire) |=> (mem_req_o && $stable(mem_addr_o)));
    a_r9_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i && !expire) |=>
        (reg_req_o && $stable(reg_we_o) && $stable(reg_addr_o) && $stable(reg_wdata_o)));
    a_r3_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> ((reg_wdata_o & hi_q) == hi_q));
    a_r3_lo_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> ((reg_wdata_o & lo_q & ~hi_q) == '0));
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o && !err_o));
    a_r6_err_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && !busy_o));
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/sim_cfg_table_walker.sv
module sim_cfg_table_walker;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int TMO = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic          busy_o, done_o, err_o;
    logic          mem_req_o, reg_req_o, reg_we_o;
    logic [AW-1:0] mem_addr_o, reg_addr_o;
    logic [DW-1:0] reg_wdata_o;
    logic          mem_ack_i = 1'b0, reg_ack_i = 1'b0;
    logic [DW-1:0] mem_rdata_i = '0, reg_rdata_i = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem   [256];
    logic [31:0] regs  [16];
    logic [31:0] mlog  [64];
    int          mlog_n = 0;
    int          wlog  [16];
    int          wlog_n = 0;
    int          rd_n = 0;
    int          mlat = 0, rlat = 0;
    int          mcnt = 0, rcnt = 0;

    always #2 clk = ~clk;

    cfg_table_walker #(.AW(AW), .DW(DW), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .reg_req_o(reg_req_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
        .reg_wdata_o(reg_wdata_o), .reg_ack_i(reg_ack_i), .reg_rdata_i(reg_rdata_i)
    );

    // memory responder: acknowledge in request cycle mlat (0-based)
    always @(negedge clk) begin
        if (mem_ack_i) begin mem_ack_i = 1'b0; mcnt = 0; end
        if (mem_req_o) begin
            if (mcnt >= mlat) begin
                mem_ack_i   = 1'b1;
                mem_rdata_i = mem[mem_addr_o[9:2]];
                if (mlog_n < 64) mlog[mlog_n] = mem_addr_o;
                mlog_n++;
            end else mcnt++;
        end else mcnt = 0;
    end

    // register responder with the same latency convention
    always @(negedge clk) begin
        if (reg_ack_i) begin reg_ack_i = 1'b0; rcnt = 0; end
        if (reg_req_o) begin
            if (rcnt >= rlat) begin
                reg_ack_i = 1'b1;
                if (reg_we_o) begin
                    regs[reg_addr_o[5:2]] = reg_wdata_o;
                    if (wlog_n < 16) wlog[wlog_n] = int'(reg_addr_o[5:2]);
                    wlog_n++;
                end else begin
                    reg_rdata_i = regs[reg_addr_o[5:2]];
                    rd_n++;
                end
            end else rcnt++;
        end else rcnt = 0;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_entry(input int byte_addr, input logic [31:0] a,
                             input logic [31:0] h, input logic [31:0] l);
        mem[byte_addr/4]     = a;
        mem[byte_addr/4 + 1] = h;
        mem[byte_addr/4 + 2] = l;
    endtask

    task automatic clear_logs();
        mlog_n = 0; wlog_n = 0; rd_n = 0;
    endtask

    task automatic pulse_start(input logic [31:0] b);
        @(negedge clk); #1;
        base_i = b; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
        #1;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] h,
                                          input logic [31:0] l);
        return (o & ~l) | h;
    endfunction

    logic [31:0] exp_r [16];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) regs[i] = 32'h1111_0000 * i + 32'h5A;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 busy", {31'b0, busy_o}, 32'd0);
        chk("R1 done", {31'b0, done_o}, 32'd0);
        chk("R1 err",  {31'b0, err_o},  32'd0);
        chk("R1 reqs", {30'b0, mem_req_o, reg_req_o}, 32'd0);
        rst_n = 1'b1;

        // R2/R3/R4/R5: seven-entry table at 0x40, registers 1..7
        for (int k = 1; k <= 6; k++) begin
            logic [31:0] h, l;
            h = (32'h0101_0101 * k) << k;
            l = 32'hFFFF_0000 >> k;
            put_entry(32'h40 + 12*(k-1), 32'(4*k), h, l);
            exp_r[k] = merge(regs[k], h, l);
        end
        regs[7] = 32'h1234_5678;
        put_entry(32'h40 + 72, 32'd28, 32'h0000_00FF, 32'h0000_FFFF);
        exp_r[7] = 32'h1234_00FF;
        put_entry(32'h40 + 84, 0, 0, 0);
        clear_logs();
        pulse_start(32'h40);
        chk("R2 busy after start", {31'b0, busy_o}, 32'd1);
        wait_idle();
        for (int k = 1; k <= 7; k++) chk("R3 merged value", regs[k], exp_r[k]);
        chk("R4 memory read count", 32'(mlog_n), 32'd24);
        for (int j = 0; j < 24; j++) chk("R2 R4 read address order", mlog[j], 32'h40 + 32'(4*j));
        chk("R4 write count", 32'(wlog_n), 32'd7);
        for (int j = 0; j < 7 && j < wlog_n; j++) chk("R4 write order", 32'(wlog[j]), 32'(j+1));
        chk("R5 done", {31'b0, done_o}, 32'd1);
        chk("R5 err low", {31'b0, err_o}, 32'd0);

        // R8: done holds, then a start clears it
        repeat (10) @(negedge clk);
        #1;
        chk("R8 done held", {31'b0, done_o}, 32'd1);
        put_entry(32'h180, 0, 0, 0);
        clear_logs();
        pulse_start(32'h180);
        chk("R8 done cleared by start", {31'b0, done_o}, 32'd0);
        wait_idle();
        // R5: immediate sentinel, no register access
        chk("R5 sentinel reads", 32'(mlog_n), 32'd3);
        chk("R5 sentinel no reg access", 32'(wlog_n + rd_n), 32'd0);
        chk("R5 sentinel done", {31'b0, done_o}, 32'd1);

        // R5: address-zero entry with nonzero mask is applied
        regs[0] = 32'h1; regs[15] = 32'hDEAD_BEEF;
        put_entry(32'h200, 0, 32'h8, 0);
        put_entry(32'h20C, 32'd60, 0, 32'hFFFF_FFFF);
        put_entry(32'h218, 0, 0, 0);
        clear_logs();
        pulse_start(32'h200);
        wait_idle();
        chk("R5 addr-zero entry applied", regs[0], 32'h9);
        chk("R5 following entry applied", regs[15], 32'h0);
        chk("R5 read count", 32'(mlog_n), 32'd9);

        // R7: start while busy is ignored
        regs[12] = 32'h0; regs[13] = 32'h0;
        put_entry(32'h300, 32'd52, 32'hF0, 0);
        put_entry(32'h30C, 0, 0, 0);
        put_entry(32'h100, 32'd48, 32'h3C, 0);
        put_entry(32'h10C, 0, 0, 0);
        clear_logs();
        mlat = 2; rlat = 2;
        pulse_start(32'h100);
        @(negedge clk); #1;
        base_i = 32'h300; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        wait_idle();
        chk("R7 own table applied", regs[12], 32'h3C);
        chk("R7 second start ignored", regs[13], 32'h0);
        chk("R7 read count", 32'(mlog_n), 32'd6);

        // R6: latency sweep up to TMO-1, acknowledge wins in the last cycle
        for (int lat = 0; lat < TMO; lat++) begin
            regs[3] = 32'hFFFF_0000; regs[4] = 32'h0000_FFFF;
            put_entry(32'h100, 32'd12, 32'h0000_00F0, 32'h00FF_0000);
            put_entry(32'h10C, 32'd16, 32'h8000_0000, 32'h0000_000F);
            put_entry(32'h118, 0, 0, 0);
            mlat = lat; rlat = lat;
            clear_logs();
            pulse_start(32'h100);
            wait_idle();
            chk("R6 in-limit reg3", regs[3], 32'hFF00_00F0);
            chk("R6 in-limit reg4", regs[4], 32'h8000_FFF0);
            chk("R6 in-limit no err", {31'b0, err_o}, 32'd0);
        end

        // R6: register port answers one cycle too late
        regs[3] = 32'h77; regs[4] = 32'h88;
        mlat = 0; rlat = TMO;
        clear_logs();
        pulse_start(32'h100);
        wait_idle();
        chk("R6 reg timeout err", {31'b0, err_o}, 32'd1);
        chk("R6 reg timeout done", {31'b0, done_o}, 32'd1);
        chk("R6 reg timeout no write", regs[3], 32'h77);
        repeat (TMO + 2) @(negedge clk);
        #1;
        chk("R6 no access after stop", 32'(wlog_n + rd_n), 32'd0);

        // R6/R8: memory port too late; new start clears err first
        mlat = TMO; rlat = 0;
        clear_logs();
        pulse_start(32'h100);
        chk("R8 err cleared by start", {31'b0, err_o}, 32'd0);
        wait_idle();
        chk("R6 mem timeout err", {31'b0, err_o}, 32'd1);
        chk("R6 mem timeout no reg access", 32'(wlog_n + rd_n), 32'd0);
        chk("R6 mem timeout reg3 kept", regs[3], 32'h77);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule